// File: doc/BRIEF.md
# Event Notification Routing Sequencer

This block takes one event trigger at a time, named by a descriptor block, a descriptor index and a payload word. It then walks the routing decision for that descriptor. It fetches the descriptor and checks that it is valid. When the descriptor asks for it, the payload goes to an external queue engine and the queue position is written back. Two-bit pending/queued state machines coalesce repeated notifications. A presenter is asked to deliver to the target context. When the presenter misses, a priority bit is recorded in the target's pending-priority byte. The sequencer can also escalate, which restarts the whole sequence on a second descriptor named inside the first one.

Descriptor storage, target-context storage, the presenter and the queue datapath all sit outside the block. Descriptor and context reads return their data one cycle after the read strobe. The presenter answers after any number of cycles. Each trigger ends with a one-cycle completion pulse that carries a result code.

Top module: `evr_route_seq`

## Requirements
- R1: After reset `trig_ready` is 1 and `done` is 0. A trigger is taken only while `trig_ready` is 1. `trig_ready` stays 0 until the matching one-cycle `done` pulse, and `trig_ready` is 1 while `done` is high.
- R2: A descriptor whose valid flag is 0 ends the trigger with result code 1 and causes no queue request, no write and no presenter request.
- R3: When the enqueue flag is set, one queue request is issued. Its slot is the descriptor's queue index and its word is {generation bit, 31-bit payload}. The descriptor is then written back with the index advanced modulo 2^QLG, and the generation bit inverts when the index wraps to 0.
- R4: A descriptor with the silent flag set makes no presenter request and goes straight to the escalation phase.
- R5: Format 0 with priority 0xFF is masked and ends with code 0. Format 1 with priority 0xFF is not masked.
- R6: Unless always-notify is set, the notification state (bit 1 = pending, bit 0 = queued) moves 00→10 and notifies, moves 10→11 and 11→11 without notifying, and leaves 01 as 01 without notifying. The descriptor is written back only when the state changed. With no notification the trigger ends with code 0.
- R7: With always-notify set, the notification state is neither consulted nor written.
- R8: An invalid target context ends with code 2. A valid target produces one presenter request carrying the format, priority, target block and target index.
- R9: A presenter hit ends with code 0. On a miss with backlog set and priority p < 8, bit (7−p) is ORed into the pending-priority byte and the byte is written back. With p ≥ 8, no write is made.
- R10: Backlog with format 1 on a presenter miss ends with code 3.
- R11: When escalation is enabled, the escalation state follows the R6 rule unless the unconditional flag is set. On notification the sequence restarts with the escalation block, index and payload held in the descriptor. Without escalation the trigger ends with code 0.
- R12: At most MAX_ESC (4) chained restarts are made per trigger. A further restart ends with code 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_valid | input | 1 | Trigger present |
| trig_blk | input | BLK_W | Trigger descriptor block |
| trig_idx | input | IDX_W | Trigger descriptor index |
| trig_data | input | PAY_W | Trigger payload |
| trig_ready | output | 1 | Sequencer idle |
| desc_rd_en | output | 1 | Descriptor read strobe |
| desc_rd_blk | output | BLK_W | Descriptor read block |
| desc_rd_idx | output | IDX_W | Descriptor read index |
| desc_rd_data | input | DESC_W | Descriptor, one cycle after strobe |
| desc_wr_en | output | 1 | Descriptor write strobe |
| desc_wr_blk | output | BLK_W | Descriptor write block |
| desc_wr_idx | output | IDX_W | Descriptor write index |
| desc_wr_data | output | DESC_W | Descriptor write data |
| ctx_rd_en | output | 1 | Target context read strobe |
| ctx_blk | output | BLK_W | Target context block |
| ctx_idx | output | IDX_W | Target context index |
| ctx_rd_valid | input | 1 | Target context valid, one cycle after strobe |
| ctx_rd_pend | input | 8 | Pending-priority byte, one cycle after strobe |
| ctx_wr_en | output | 1 | Pending-priority write strobe |
| ctx_wr_pend | output | 8 | Pending-priority write data |
| pres_req | output | 1 | Presenter request pulse |
| pres_fmt | output | 1 | Request format |
| pres_prio | output | 8 | Request priority |
| pres_blk | output | BLK_W | Request target block |
| pres_idx | output | IDX_W | Request target index |
| pres_rsp_valid | input | 1 | Presenter answer |
| pres_rsp_hit | input | 1 | Target was found |
| enq_req | output | 1 | Queue write request |
| enq_slot | output | QLG | Queue slot |
| enq_word | output | PAY_W+1 | Generation bit and payload |
| done | output | 1 | Trigger finished |
| done_code | output | 3 | Result code |

## Verification
Single triggers are applied against prepared descriptor sets. One set walks the notification state through 00, 10 and 11 on repeated triggers of the same descriptor, which separates the three R6 transitions. Another set holds the state at 01. Queue traffic is tried at the last slot and then the first, so a wrap without generation inversion shows up as a wrong queue word. Hit, miss and invalid targets, both backlog priority cases and format 1 are mixed so that each result code comes from its own path. Escalation is tried unconditional from a silent descriptor, conditional on a fresh and then a pending escalation state, and as a self-loop that reaches the depth limit.

// File: rtl/evr_pkg.sv
package evr_pkg;
  parameter int BLK_W = 4;
  parameter int IDX_W = 8;
  parameter int PAY_W = 31;
  parameter int QLG   = 4;

  typedef enum logic [2:0] {
    FIN_OK       = 3'd0,
    FIN_BAD_DESC = 3'd1,
    FIN_BAD_TGT  = 3'd2,
    FIN_BAD_CFG  = 3'd3,
    FIN_DEPTH    = 3'd4
  } fin_code_e;

  typedef struct packed {
    logic             valid;
    logic             enq_en;
    logic             silent;
    logic             always_ntf;
    logic             backlog;
    logic             esc_en;
    logic             esc_uncond;
    logic             fmt;
    logic [7:0]       prio;
    logic [BLK_W-1:0] tgt_blk;
    logic [IDX_W-1:0] tgt_idx;
    logic [1:0]       pq_ntf;
    logic [1:0]       pq_esc;
    logic             gen;
    logic [QLG-1:0]   qidx;
    logic [BLK_W-1:0] esc_blk;
    logic [IDX_W-1:0] esc_idx;
    logic [PAY_W-1:0] esc_data;
  } evr_desc_t;

  localparam int DESC_W = $bits(evr_desc_t);
endpackage

// File: rtl/evr_pq_stage.sv
module evr_pq_stage (
  input  logic [1:0] pq_in,
  output logic [1:0] pq_out,
  output logic       fire,
  output logic       changed
);
  always_comb begin
    fire = 1'b0;
    unique case (pq_in)
      2'b00: begin pq_out = 2'b10; fire = 1'b1; end
      2'b10: pq_out = 2'b11;
      2'b11: pq_out = 2'b11;
      default: pq_out = 2'b01;
    endcase
    changed = (pq_out != pq_in);
  end
endmodule

// File: rtl/evr_queue_step.sv
module evr_queue_step #(
  parameter int QLG = 4
) (
  input  logic [QLG-1:0] idx_in,
  input  logic           gen_in,
  output logic [QLG-1:0] idx_out,
  output logic           gen_out
);
  always_comb begin
    idx_out = idx_in + 1'b1;
    gen_out = gen_in ^ (idx_out == '0);
  end
endmodule

// File: rtl/evr_backlog_mask.sv
module evr_backlog_mask (
  input  logic [7:0] prio,
  input  logic [7:0] pend_in,
  output logic [7:0] pend_out,
  output logic       apply
);
  for (genvar g = 0; g < 8; g++) begin : g_bit
    assign pend_out[g] = pend_in[g] | (prio == 8'(7 - g));
  end
  assign apply = (prio < 8'd8);
endmodule

// File: rtl/evr_route_seq.sv
module evr_route_seq
  import evr_pkg::*;
#(
  parameter int MAX_ESC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_valid,
  input  logic [BLK_W-1:0] trig_blk,
  input  logic [IDX_W-1:0] trig_idx,
  input  logic [PAY_W-1:0] trig_data,
  output logic             trig_ready,
  output logic             desc_rd_en,
  output logic [BLK_W-1:0] desc_rd_blk,
  output logic [IDX_W-1:0] desc_rd_idx,
  input  evr_desc_t        desc_rd_data,
  output logic             desc_wr_en,
  output logic [BLK_W-1:0] desc_wr_blk,
  output logic [IDX_W-1:0] desc_wr_idx,
  output evr_desc_t        desc_wr_data,
  output logic             ctx_rd_en,
  output logic [BLK_W-1:0] ctx_blk,
  output logic [IDX_W-1:0] ctx_idx,
  input  logic             ctx_rd_valid,
  input  logic [7:0]       ctx_rd_pend,
  output logic             ctx_wr_en,
  output logic [7:0]       ctx_wr_pend,
  output logic             pres_req,
  output logic             pres_fmt,
  output logic [7:0]       pres_prio,
  output logic [BLK_W-1:0] pres_blk,
  output logic [IDX_W-1:0] pres_idx,
  input  logic             pres_rsp_valid,
  input  logic             pres_rsp_hit,
  output logic             enq_req,
  output logic [QLG-1:0]   enq_slot,
  output logic [PAY_W:0]   enq_word,
  output logic             done,
  output logic [2:0]       done_code
);
  localparam int DEPTH_W = $clog2(MAX_ESC + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_RD, S_LOAD, S_ENQ, S_ROUTE, S_RD_CTX,
    S_CTX_CHK, S_PRES, S_WAIT, S_ESC
  } st_e;

  st_e              state_q, state_d;
  logic [BLK_W-1:0] blk_q, blk_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [PAY_W-1:0] data_q, data_d;
  evr_desc_t        dsc_q, dsc_d;
  logic [7:0]       pend_q, pend_d;
  logic [DEPTH_W-1:0] depth_q, depth_d;
  logic             done_q, done_d;
  fin_code_e        code_q, code_d;

  logic [1:0]     pqn_out, pqe_out;
  logic           pqn_fire, pqn_chg, pqe_fire, pqe_chg;
  logic [QLG-1:0] nq_idx;
  logic           nq_gen;
  logic [7:0]     bl_pend;
  logic           bl_apply;

  evr_pq_stage u_pq_ntf (.pq_in(dsc_q.pq_ntf), .pq_out(pqn_out),
                         .fire(pqn_fire), .changed(pqn_chg));
  evr_pq_stage u_pq_esc (.pq_in(dsc_q.pq_esc), .pq_out(pqe_out),
                         .fire(pqe_fire), .changed(pqe_chg));
  evr_queue_step #(.QLG(QLG)) u_qstep (.idx_in(dsc_q.qidx), .gen_in(dsc_q.gen),
                                       .idx_out(nq_idx), .gen_out(nq_gen));
  evr_backlog_mask u_blmask (.prio(dsc_q.prio), .pend_in(pend_q),
                             .pend_out(bl_pend), .apply(bl_apply));

  assign trig_ready  = (state_q == S_IDLE);
  assign desc_rd_blk = blk_q;
  assign desc_rd_idx = idx_q;
  assign desc_wr_blk = blk_q;
  assign desc_wr_idx = idx_q;
  assign desc_wr_data = dsc_d;
  assign ctx_blk     = dsc_q.tgt_blk;
  assign ctx_idx     = dsc_q.tgt_idx;
  assign ctx_wr_pend = bl_pend;
  assign pres_fmt    = dsc_q.fmt;
  assign pres_prio   = dsc_q.prio;
  assign pres_blk    = dsc_q.tgt_blk;
  assign pres_idx    = dsc_q.tgt_idx;
  assign enq_slot    = dsc_q.qidx;
  assign enq_word    = {dsc_q.gen, data_q};
  assign done        = done_q;
  assign done_code   = code_q;

  always_comb begin
    state_d    = state_q;
    blk_d      = blk_q;
    idx_d      = idx_q;
    data_d     = data_q;
    dsc_d      = dsc_q;
    pend_d     = pend_q;
    depth_d    = depth_q;
    done_d     = 1'b0;
    code_d     = code_q;
    desc_rd_en = 1'b0;
    desc_wr_en = 1'b0;
    ctx_rd_en  = 1'b0;
    ctx_wr_en  = 1'b0;
    pres_req   = 1'b0;
    enq_req    = 1'b0;
    unique case (state_q)
      S_IDLE: if (trig_valid) begin
        blk_d   = trig_blk;
        idx_d   = trig_idx;
        data_d  = trig_data;
        depth_d = '0;
        state_d = S_RD;
      end
      S_RD: begin
        desc_rd_en = 1'b1;
        state_d    = S_LOAD;
      end
      S_LOAD: begin
        dsc_d = desc_rd_data;
        if (!desc_rd_data.valid) begin
          state_d = S_IDLE; done_d = 1'b1; code_d = FIN_BAD_DESC;
        end else if (desc_rd_data.enq_en) begin
          state_d = S_ENQ;
        end else begin
          state_d = S_ROUTE;
        end
      end
      S_ENQ: begin
        enq_req    = 1'b1;
        dsc_d.qidx = nq_idx;
        dsc_d.gen  = nq_gen;
        desc_wr_en = 1'b1;
        state_d    = S_ROUTE;
      end
      S_ROUTE: begin
        if (dsc_q.silent) begin
          state_d = S_ESC;
        end else if (!dsc_q.fmt && dsc_q.prio == 8'hFF) begin
          state_d = S_IDLE; done_d = 1'b1; code_d = FIN_OK;
        end else if (dsc_q.always_ntf) begin
          state_d = S_RD_CTX;
        end else begin
          dsc_d.pq_ntf = pqn_out;
          desc_wr_en   = pqn_chg;
          if (pqn_fire) state_d = S_RD_CTX;
          else begin
            state_d = S_IDLE; done_d = 1'b1; code_d = FIN_OK;
          end
        end
      end
      S_RD_CTX: begin
        ctx_rd_en = 1'b1;
        state_d   = S_CTX_CHK;
      end
      S_CTX_CHK: begin
        if (!ctx_rd_valid) begin
          state_d = S_IDLE; done_d = 1'b1; code_d = FIN_BAD_TGT;
        end else begin
          pend_d  = ctx_rd_pend;
          state_d = S_PRES;
        end
      end
      S_PRES: begin
        pres_req = 1'b1;
        state_d  = S_WAIT;
      end
      S_WAIT: if (pres_rsp_valid) begin
        if (pres_rsp_hit) begin
          state_d = S_IDLE; done_d = 1'b1; code_d = FIN_OK;
        end else if (dsc_q.backlog && dsc_q.fmt) begin
          state_d = S_IDLE; done_d = 1'b1; code_d = FIN_BAD_CFG;
        end else begin
          ctx_wr_en = dsc_q.backlog && bl_apply;
          state_d   = S_ESC;
        end
      end
      S_ESC: begin
        if (!dsc_q.esc_en) begin
          state_d = S_IDLE; done_d = 1'b1; code_d = FIN_OK;
        end else begin
          if (!dsc_q.esc_uncond) begin
            dsc_d.pq_esc = pqe_out;
            desc_wr_en   = pqe_chg;
          end
          if (!dsc_q.esc_uncond && !pqe_fire) begin
            state_d = S_IDLE; done_d = 1'b1; code_d = FIN_OK;
          end else if (depth_q == DEPTH_W'(MAX_ESC)) begin
            state_d = S_IDLE; done_d = 1'b1; code_d = FIN_DEPTH;
          end else begin
            depth_d = depth_q + 1'b1;
            blk_d   = dsc_q.esc_blk;
            idx_d   = dsc_q.esc_idx;
            data_d  = dsc_q.esc_data;
            state_d = S_RD;
          end
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      blk_q   <= '0;
      idx_q   <= '0;
      data_q  <= '0;
      dsc_q   <= '0;
      pend_q  <= '0;
      depth_q <= '0;
      done_q  <= 1'b0;
      code_q  <= FIN_OK;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (state_q == S_IDLE || state_q == S_ESC) begin
        blk_q   <= blk_d;
        idx_q   <= idx_d;
        data_q  <= data_d;
        depth_q <= depth_d;
      end
      if (state_q != S_IDLE) dsc_q <= dsc_d;
      if (state_q == S_CTX_CHK) pend_q <= pend_d;
      if (done_d) code_q <= code_d;
    end
  end

  // R1: completion only from idle, one cycle long
  a_r1_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> trig_ready);
  a_r1_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R2: invalid descriptor reported with its code
  a_r2_bad_desc: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_LOAD && !desc_rd_data.valid) |=> (done && done_code == 3'd1));
  // R3: queue write-back carries the advanced index
  a_r3_qidx_adv: assert property (@(posedge clk) disable iff (!rst_n)
    enq_req |-> (desc_wr_en && desc_wr_data.qidx == QLG'(enq_slot + 1'b1)));
  a_r3_gen_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (enq_req && enq_slot == {QLG{1'b1}}) |-> (desc_wr_data.gen != enq_word[PAY_W]));
  // R6: notification-state writes only on change
  a_r6_write_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_ROUTE && desc_wr_en) |-> (desc_wr_data.pq_ntf != dsc_q.pq_ntf));
  // R9: backlog only adds one bit
  a_r9_pend_superset: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_wr_en |-> (((ctx_wr_pend & pend_q) == pend_q) &&
                   ($countones(ctx_wr_pend ^ pend_q) <= 1)));
  // R12: depth never exceeds limit
  a_r12_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    depth_q <= DEPTH_W'(MAX_ESC));
  // R8: one port strobe at a time
  a_r8_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({desc_rd_en, ctx_rd_en, pres_req, ctx_wr_en}));
endmodule

// File: tb/evr_route_seq_tb.sv
module evr_route_seq_tb;
  import evr_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int K_ENQ = 0, K_DWR = 1, K_PRES = 2, K_CWR = 3, K_DONE = 4;

  typedef struct {
    int           kind;
    logic [31:0]  a;
    logic [127:0] b;
    string        tag;
  } ev_t;

  logic clk = 1'b0;
  logic rst_n;
  logic trig_valid;
  logic [BLK_W-1:0] trig_blk;
  logic [IDX_W-1:0] trig_idx;
  logic [PAY_W-1:0] trig_data;
  logic trig_ready;
  logic desc_rd_en, desc_wr_en;
  logic [BLK_W-1:0] desc_rd_blk, desc_wr_blk, ctx_blk, pres_blk;
  logic [IDX_W-1:0] desc_rd_idx, desc_wr_idx, ctx_idx, pres_idx;
  evr_desc_t desc_rd_data, desc_wr_data;
  logic ctx_rd_en, ctx_rd_valid, ctx_wr_en;
  logic [7:0] ctx_rd_pend, ctx_wr_pend, pres_prio;
  logic pres_req, pres_fmt, pres_rsp_valid, pres_rsp_hit;
  logic enq_req;
  logic [QLG-1:0] enq_slot;
  logic [PAY_W:0] enq_word;
  logic done;
  logic [2:0] done_code;

  int errors = 0, checks = 0, donecnt = 0;
  ev_t expq[$];

  evr_desc_t smem[int];
  evr_desc_t mmem[int];
  bit  s_cv[int];
  bit  m_cv[int];
  logic [7:0] s_cp[int];
  logic [7:0] m_cp[int];
  bit  disp[int];

  always #(CLK_PERIOD/2) clk = ~clk;

  evr_route_seq u_dut (.*);

  function automatic int key(input logic [BLK_W-1:0] b, input logic [IDX_W-1:0] i);
    return int'({b, i});
  endfunction

  // external stubs
  int pcnt = 0;
  int pkey = 0;
  always @(posedge clk) begin
    if (desc_rd_en)
      desc_rd_data <= smem.exists(key(desc_rd_blk, desc_rd_idx)) ?
                      smem[key(desc_rd_blk, desc_rd_idx)] : '0;
    if (desc_wr_en) smem[key(desc_wr_blk, desc_wr_idx)] = desc_wr_data;
    if (ctx_rd_en) begin
      ctx_rd_valid <= s_cv.exists(key(ctx_blk, ctx_idx)) ? s_cv[key(ctx_blk, ctx_idx)] : 1'b0;
      ctx_rd_pend  <= s_cp.exists(key(ctx_blk, ctx_idx)) ? s_cp[key(ctx_blk, ctx_idx)] : 8'h00;
    end
    if (ctx_wr_en) s_cp[key(ctx_blk, ctx_idx)] = ctx_wr_pend;
    pres_rsp_valid <= 1'b0;
    if (pcnt != 0) begin
      pcnt = pcnt - 1;
      if (pcnt == 0) begin
        pres_rsp_valid <= 1'b1;
        pres_rsp_hit   <= disp.exists(pkey);
      end
    end
    if (pres_req) begin
      pcnt = 3;
      pkey = key(pres_blk, pres_idx);
    end
  end

  task automatic expect_ev(input int k, input logic [31:0] a, input logic [127:0] b,
                           input string tag);
    ev_t e;
    e.kind = k; e.a = a; e.b = b; e.tag = tag;
    expq.push_back(e);
  endtask

  task automatic cmp(input int k, input logic [31:0] a, input logic [127:0] b);
    ev_t e;
    checks++;
    if (expq.size() == 0) begin
      errors++;
      $display("FAIL unexpected event: kind %0d a %h b %h, expected none", k, a, b);
    end else begin
      e = expq.pop_front();
      if (e.kind != k || e.a !== a || e.b !== b) begin
        errors++;
        $display("FAIL %s: kind %0d a %h b %h, expected kind %0d a %h b %h",
                 e.tag, k, a, b, e.kind, e.a, e.b);
      end
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (enq_req)    cmp(K_ENQ, 32'(enq_slot), 128'(enq_word));
    if (desc_wr_en) cmp(K_DWR, 32'(key(desc_wr_blk, desc_wr_idx)), 128'(desc_wr_data));
    if (pres_req)   cmp(K_PRES, 32'(key(pres_blk, pres_idx)), 128'({pres_fmt, pres_prio}));
    if (ctx_wr_en)  cmp(K_CWR, 32'(key(ctx_blk, ctx_idx)), 128'(ctx_wr_pend));
    if (done) begin
      cmp(K_DONE, 32'(done_code), 128'(0));
      donecnt++;
    end
  end

  // behavioural reference
  task automatic pq_rule(input logic [1:0] i, output logic [1:0] o, output bit f);
    f = 0;
    if (i == 2'b00) begin o = 2'b10; f = 1; end
    else if (i == 2'b01) o = 2'b01;
    else o = 2'b11;
  endtask

  task automatic model(input logic [BLK_W-1:0] b0, input logic [IDX_W-1:0] i0,
                       input logic [PAY_W-1:0] d0);
    int k = key(b0, i0);
    int depth = 0;
    logic [PAY_W-1:0] data = d0;
    evr_desc_t d;
    logic [1:0] np;
    bit f;
    int t;
    forever begin
      if (!mmem.exists(k) || !mmem[k].valid) begin expect_ev(K_DONE, 1, 0, "R2"); return; end
      d = mmem[k];
      if (d.enq_en) begin
        expect_ev(K_ENQ, 32'(d.qidx), 128'({d.gen, data}), "R3");
        d.qidx = QLG'((int'(d.qidx) + 1) % (1 << QLG));
        if (d.qidx == 0) d.gen = ~d.gen;
        mmem[k] = d;
        expect_ev(K_DWR, 32'(k), 128'(d), "R3");
      end
      if (!d.silent) begin
        if (!d.fmt && d.prio == 8'hFF) begin expect_ev(K_DONE, 0, 0, "R5"); return; end
        if (!d.always_ntf) begin
          pq_rule(d.pq_ntf, np, f);
          if (np != d.pq_ntf) begin
            d.pq_ntf = np; mmem[k] = d;
            expect_ev(K_DWR, 32'(k), 128'(d), "R6");
          end
          if (!f) begin expect_ev(K_DONE, 0, 0, "R6"); return; end
        end
        t = key(d.tgt_blk, d.tgt_idx);
        if (!m_cv.exists(t) || !m_cv[t]) begin expect_ev(K_DONE, 2, 0, "R8"); return; end
        expect_ev(K_PRES, 32'(t), 128'({d.fmt, d.prio}), "R8");
        if (disp.exists(t)) begin expect_ev(K_DONE, 0, 0, "R9"); return; end
        if (d.backlog) begin
          if (d.fmt) begin expect_ev(K_DONE, 3, 0, "R10"); return; end
          if (d.prio < 8) begin
            m_cp[t] = m_cp[t] | (8'h01 << (7 - int'(d.prio)));
            expect_ev(K_CWR, 32'(t), 128'(m_cp[t]), "R9");
          end
        end
      end
      if (!d.esc_en) begin expect_ev(K_DONE, 0, 0, "R11"); return; end
      if (!d.esc_uncond) begin
        pq_rule(d.pq_esc, np, f);
        if (np != d.pq_esc) begin
          d.pq_esc = np; mmem[k] = d;
          expect_ev(K_DWR, 32'(k), 128'(d), "R11");
        end
        if (!f) begin expect_ev(K_DONE, 0, 0, "R11"); return; end
      end
      if (depth == 4) begin expect_ev(K_DONE, 4, 0, "R12"); return; end
      depth++;
      k = key(d.esc_blk, d.esc_idx);
      data = d.esc_data;
    end
  endtask

  task automatic put_desc(input logic [BLK_W-1:0] b, input logic [IDX_W-1:0] i,
                          input evr_desc_t d);
    smem[key(b, i)] = d;
    mmem[key(b, i)] = d;
  endtask

  task automatic put_ctx(input logic [BLK_W-1:0] b, input logic [IDX_W-1:0] i,
                         input bit v, input logic [7:0] p, input bit hit);
    s_cv[key(b, i)] = v; m_cv[key(b, i)] = v;
    s_cp[key(b, i)] = p; m_cp[key(b, i)] = p;
    if (hit) disp[key(b, i)] = 1'b1;
  endtask

  function automatic evr_desc_t base(input logic [IDX_W-1:0] tgt);
    evr_desc_t d = '0;
    d.valid = 1'b1; d.prio = 8'd3; d.tgt_blk = 4'd1; d.tgt_idx = tgt;
    return d;
  endfunction

  task automatic fire(input logic [BLK_W-1:0] b, input logic [IDX_W-1:0] i,
                      input logic [PAY_W-1:0] data, input string tag);
    int start = donecnt;
    int n = 0;
    model(b, i, data);
    @(negedge clk);
    while (!trig_ready) @(negedge clk);
    trig_valid = 1'b1; trig_blk = b; trig_idx = i; trig_data = data;
    @(negedge clk);
    trig_valid = 1'b0;
    while (donecnt == start && n < 500) begin @(negedge clk); n++; end
    checks++;
    if (donecnt == start || expq.size() != 0) begin
      errors++;
      $display("FAIL %s: done %0d pending %0d, expected done 1 pending 0",
               tag, donecnt - start, expq.size());
      expq.delete();
    end
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin @(posedge clk); cyc++; end
    errors++;
    $display("FAIL watchdog: cycles %0d, expected completion", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    evr_desc_t d;
    rst_n = 1'b0; trig_valid = 1'b0; trig_blk = '0; trig_idx = '0; trig_data = '0;
    desc_rd_data = '0; ctx_rd_valid = 1'b0; ctx_rd_pend = '0;
    pres_rsp_valid = 1'b0; pres_rsp_hit = 1'b0;
    put_ctx(1, 8'h10, 1, 8'h00, 1);
    put_ctx(1, 8'h20, 1, 8'h01, 0);
    put_ctx(1, 8'h30, 0, 8'h00, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (trig_ready !== 1'b1 || done !== 1'b0) begin
      errors++;
      $display("FAIL R1: ready %b done %b, expected ready 1 done 0", trig_ready, done);
    end

    fire(2, 8'h01, 31'h11, "R2");                 // no descriptor
    d = base(8'h10); put_desc(2, 8'h02, d);
    fire(2, 8'h02, 31'h12, "R6");                 // 00 -> 10, hit
    fire(2, 8'h02, 31'h13, "R6");                 // 10 -> 11
    fire(2, 8'h02, 31'h14, "R6");                 // 11 stays
    d = base(8'h10); d.pq_ntf = 2'b01; put_desc(2, 8'h03, d);
    fire(2, 8'h03, 31'h15, "R6");                 // 01 stays
    d = base(8'h10); d.enq_en = 1; d.qidx = 4'hF; d.prio = 8'hFF; put_desc(2, 8'h04, d);
    fire(2, 8'h04, 31'h7ABC_DEF0, "R3");          // last slot, masked
    fire(2, 8'h04, 31'h0123_4567, "R5");          // wrapped slot
    d = base(8'h20); d.always_ntf = 1; d.pq_ntf = 2'b11; d.backlog = 1; put_desc(2, 8'h05, d);
    fire(2, 8'h05, 31'h16, "R7");                 // bypass, miss, backlog bit 4
    d = base(8'h20); d.always_ntf = 1; d.backlog = 1; d.fmt = 1; d.prio = 8'hFF;
    put_desc(2, 8'h06, d);
    fire(2, 8'h06, 31'h17, "R10");
    d = base(8'h10); d.always_ntf = 1; d.enq_en = 1; d.qidx = 4'h2; put_desc(3, 8'h01, d);
    d = base(8'h10); d.silent = 1; d.esc_en = 1; d.esc_uncond = 1;
    d.esc_blk = 3; d.esc_idx = 8'h01; d.esc_data = 31'h5555_1234; put_desc(2, 8'h07, d);
    fire(2, 8'h07, 31'h18, "R4");
    d = base(8'h20); d.always_ntf = 1; d.esc_en = 1;
    d.esc_blk = 3; d.esc_idx = 8'h01; d.esc_data = 31'h0AAA_0001; put_desc(2, 8'h08, d);
    fire(2, 8'h08, 31'h19, "R11");                // esc state 00 -> 10
    fire(2, 8'h08, 31'h1A, "R11");                // 10 -> 11, stop
    d = base(8'h10); d.silent = 1; d.esc_en = 1; d.esc_uncond = 1;
    d.esc_blk = 2; d.esc_idx = 8'h09; put_desc(2, 8'h09, d);
    fire(2, 8'h09, 31'h1B, "R12");
    d = base(8'h30); d.always_ntf = 1; put_desc(2, 8'h0A, d);
    fire(2, 8'h0A, 31'h1C, "R8");
    d = base(8'h20); d.always_ntf = 1; d.backlog = 1; d.prio = 8'd9; put_desc(2, 8'h0B, d);
    fire(2, 8'h0B, 31'h1D, "R9");
    d = base(8'h20); d.always_ntf = 1; d.backlog = 1; d.prio = 8'd0; put_desc(2, 8'h0C, d);
    fire(2, 8'h0C, 31'h1E, "R9");

    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule